// File: doc/BRIEF.md
# DMA Transfer Sequencer

This block is the transfer engine of a four-channel direct memory access controller. Each channel holds its own copy of a start offset, a transfer count, a page value and a mode setting. A channel becomes a candidate for service when its request line is high and its mask bit is clear. The sequencer then asks the processor for the bus. Once the processor grants the bus, the sequencer runs transfer cycles. In each transfer cycle it raises the acknowledge line of the chosen channel, drives the 24-bit physical address built from the page and the offset, and pulses the memory and I/O strobes that match the transfer direction.

After every transfer the channel's offset moves by one, upward or downward, and its count drops by one. The transfer in which the count passes from zero to all ones is the terminal one, and it is flagged on `tc`. At that point the channel either restores its start values, if it is set to reload, or masks itself. Three pacing modes decide when the bus goes back to the processor. Single mode gives it back after every transfer. Block mode keeps it until the terminal transfer. Demand mode keeps it for as long as the request stays high.

Channels are configured through a one-cycle load port, which is meant to be used while the sequencer is idle. A load writes both the start copy and the working copy of the channel and unmasks it.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset `hrq`, `tc`, all strobes and all `dack` bits are low, and `chan_mask` reads all ones, so every channel is masked.
- R2: A channel whose mask bit is set is never serviced. Its request raises no `hrq` and no `dack`.
- R3: `dack` and the strobes are active only while `hlda` is high. `hrq` rises first and stays high for the whole hold.
- R4: In each transfer cycle exactly one `dack` bit is high, the one of the serviced channel. `mem_addr` equals {page[7:0], offset[15:0]}.
- R5: The type field sets the strobes. A value of 01 (to memory) asserts `mem_wr` and `io_rd`. A value of 10 (from memory) asserts `mem_rd` and `io_wr`. A value of 00 (check only) asserts no strobe, but `dack` is still given.
- R6: After each transfer the offset moves by +1 when the direction bit is 0 and by -1 when it is 1. It wraps within 16 bits and the page does not change.
- R7: A loaded count N gives N+1 transfers. `tc` is high only during the last of them, the one in which the count goes from 0 to all ones.
- R8: In mode 01 (single), `hrq` drops after every transfer, so each transfer has its own hold.
- R9: In mode 10 (block), all transfers run in one hold up to the terminal one, whatever `dreq` does after the start.
- R10: In mode 00 (demand), the hold ends after a transfer at whose end the channel's `dreq` is low. A later request resumes from the remaining offset and count.
- R11: When several unmasked channels request at once, the lowest-numbered one is served first.
- R12: At the terminal transfer, a channel with the reload bit clear sets its mask bit. A channel with the reload bit set keeps its mask clear and restarts from its loaded offset and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq | input | 4 | Per-channel service request |
| hrq | output | 1 | Bus hold request to the processor |
| hlda | input | 1 | Bus hold grant from the processor |
| dack | output | 4 | Per-channel transfer acknowledge |
| mem_addr | output | 24 | Physical address {page, offset}; zero outside transfers |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal transfer flag |
| prog_en | input | 1 | Load a channel's configuration this cycle |
| prog_ch | input | 2 | Channel to load |
| prog_mode | input | 2 | 00 demand, 01 single, 10 block |
| prog_dec | input | 1 | 1 = offset counts down |
| prog_auto | input | 1 | 1 = reload at the terminal transfer |
| prog_type | input | 2 | 00 check only, 01 to memory, 10 from memory |
| prog_page | input | 8 | Page value |
| prog_ofs | input | 16 | Start offset |
| prog_cnt | input | 16 | Transfer count minus one |
| chan_mask | output | 4 | Per-channel mask state |

## Verification
The assertions assume that `hlda` is raised only in answer to `hrq` and is kept high until `hrq` falls. They also assume that `prog_en` is pulsed only while the sequencer is idle. The bench's `hlda` model follows `hrq` after a programmable delay and always drops one cycle after `hrq` falls. Channels are loaded only when `hrq` has been low for several cycles. Request lines change only on falling clock edges, so the sequencer sees every stop-or-continue decision at a well-defined rising edge.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    XM_DEMAND = 2'b00,
    XM_SINGLE = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    XT_CHECK    = 2'b00,
    XT_TO_MEM   = 2'b01,
    XT_FROM_MEM = 2'b10,
    XT_NONE     = 2'b11
  } xfer_type_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_HOLD_REQ,
    SQ_MOVE
  } seq_state_e;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } strobes_t;

  // Strobe pattern belonging to a transfer type
  function automatic strobes_t type_strobes(input xfer_type_e t);
    strobes_t s;
    s = '0;
    case (t)
      XT_TO_MEM:   begin s.mem_wr = 1'b1; s.io_rd = 1'b1; end
      XT_FROM_MEM: begin s.mem_rd = 1'b1; s.io_wr = 1'b1; end
      default:     s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int OFS_W  = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [1:0]        ld_mode,
  input  logic              ld_dec,
  input  logic              ld_auto,
  input  logic [1:0]        ld_type,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [OFS_W-1:0]  ld_ofs,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              step,
  output logic              masked,
  output logic              last,
  output logic [OFS_W-1:0]  cur_ofs,
  output logic [PAGE_W-1:0] page,
  output logic [1:0]        mode,
  output logic              auto_en,
  output logic [1:0]        xtype
);

  localparam logic [OFS_W-1:0] OFS_ONE = {{(OFS_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [OFS_W-1:0] base_ofs;
  logic [CNT_W-1:0] base_cnt;
  logic [CNT_W-1:0] cur_cnt;
  logic             dec;

  // Offset after one transfer, wrapping inside OFS_W bits
  function automatic logic [OFS_W-1:0] next_ofs(input logic [OFS_W-1:0] a, input logic down);
    return down ? (a - OFS_ONE) : (a + OFS_ONE);
  endfunction

  assign last = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      masked   <= 1'b1;
      base_ofs <= '0;
      base_cnt <= '0;
      cur_ofs  <= '0;
      cur_cnt  <= '0;
      page     <= '0;
      mode     <= '0;
      dec      <= 1'b0;
      auto_en  <= 1'b0;
      xtype    <= '0;
    end else if (ld) begin
      masked   <= 1'b0;
      base_ofs <= ld_ofs;
      base_cnt <= ld_cnt;
      cur_ofs  <= ld_ofs;
      cur_cnt  <= ld_cnt;
      page     <= ld_page;
      mode     <= ld_mode;
      dec      <= ld_dec;
      auto_en  <= ld_auto;
      xtype    <= ld_type;
    end else if (step) begin
      if (last && auto_en) begin
        cur_ofs <= base_ofs;
        cur_cnt <= base_cnt;
      end else begin
        cur_ofs <= next_ofs(cur_ofs, dec);
        cur_cnt <= cur_cnt - CNT_ONE;
        if (last) masked <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_prio.sv
module dma_prio #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic [NCH-1:0]  req,
  output logic            valid,
  output logic [CH_W-1:0] idx
);

  // Lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dmaseq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int OFS_W  = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    dreq,
  output logic              hrq,
  input  logic              hlda,
  output logic [NCH-1:0]    dack,
  output logic [ADR_W-1:0]  mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              tc,
  input  logic              prog_en,
  input  logic [CH_W-1:0]   prog_ch,
  input  logic [1:0]        prog_mode,
  input  logic              prog_dec,
  input  logic              prog_auto,
  input  logic [1:0]        prog_type,
  input  logic [PAGE_W-1:0] prog_page,
  input  logic [OFS_W-1:0]  prog_ofs,
  input  logic [CNT_W-1:0]  prog_cnt,
  output logic [NCH-1:0]    chan_mask
);

  localparam logic [NCH-1:0] DACK_ONE = {{(NCH-1){1'b0}}, 1'b1};

  // Per-channel views
  logic [OFS_W-1:0]  c_ofs  [NCH];
  logic [PAGE_W-1:0] c_page [NCH];
  logic [1:0]        c_mode [NCH];
  logic [1:0]        c_type [NCH];
  logic [NCH-1:0]    c_last;
  logic [NCH-1:0]    c_auto;
  logic [NCH-1:0]    c_step;

  // Named internal events
  seq_state_e        state;
  logic [CH_W-1:0]   sel_ch;
  logic              grant_valid;
  logic [CH_W-1:0]   grant_ch;
  logic              xfer_now;
  logic              tc_hit;
  logic              sel_auto;
  logic [1:0]        sel_mode;
  strobes_t          strb;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign c_step[g] = xfer_now && (sel_ch == CH_W'(g));
      dma_chan #(.OFS_W(OFS_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (prog_en && (prog_ch == CH_W'(g))),
        .ld_mode (prog_mode),
        .ld_dec  (prog_dec),
        .ld_auto (prog_auto),
        .ld_type (prog_type),
        .ld_page (prog_page),
        .ld_ofs  (prog_ofs),
        .ld_cnt  (prog_cnt),
        .step    (c_step[g]),
        .masked  (chan_mask[g]),
        .last    (c_last[g]),
        .cur_ofs (c_ofs[g]),
        .page    (c_page[g]),
        .mode    (c_mode[g]),
        .auto_en (c_auto[g]),
        .xtype   (c_type[g])
      );
    end
  endgenerate

  dma_prio #(.NCH(NCH), .CH_W(CH_W)) u_prio (
    .req   (dreq & ~chan_mask),
    .valid (grant_valid),
    .idx   (grant_ch)
  );

  assign xfer_now = (state == SQ_MOVE) && hlda;
  assign tc_hit   = xfer_now && c_last[sel_ch];
  assign sel_auto = c_auto[sel_ch];
  assign sel_mode = c_mode[sel_ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      sel_ch <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (grant_valid) begin
            state  <= SQ_HOLD_REQ;
            sel_ch <= grant_ch;
          end
        end
        SQ_HOLD_REQ: begin
          if (hlda) state <= SQ_MOVE;
        end
        SQ_MOVE: begin
          if (!hlda) begin
            state <= SQ_HOLD_REQ;
          end else if (tc_hit) begin
            state <= SQ_IDLE;
          end else begin
            case (sel_mode)
              XM_BLOCK:  state <= SQ_MOVE;
              XM_DEMAND: state <= dreq[sel_ch] ? SQ_MOVE : SQ_IDLE;
              default:   state <= SQ_IDLE;
            endcase
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign strb     = xfer_now ? type_strobes(xfer_type_e'(c_type[sel_ch])) : '0;
  assign hrq      = (state != SQ_IDLE);
  assign dack     = xfer_now ? (DACK_ONE << sel_ch) : '0;
  assign mem_addr = xfer_now ? {c_page[sel_ch], c_ofs[sel_ch]} : '0;
  assign mem_rd   = strb.mem_rd;
  assign mem_wr   = strb.mem_wr;
  assign io_rd    = strb.io_rd;
  assign io_wr    = strb.io_wr;
  assign tc       = tc_hit;

endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hrq,
  input logic            hlda,
  input logic [NCH-1:0]  dack,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            io_rd,
  input logic            io_wr,
  input logic            tc,
  input logic            xfer_now,
  input logic            tc_hit,
  input logic [CH_W-1:0] sel_ch,
  input logic            sel_auto,
  input logic [1:0]      sel_mode,
  input logic [NCH-1:0]  chan_mask
);

  a_r3_dack_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> (hrq && hlda));

  a_r4_one_dack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  a_r5_strobe_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr) |-> (dack != '0));

  a_r5_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(io_rd && io_wr));

  a_r7_tc_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (xfer_now && (dack != '0)));

  a_r8_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_now && sel_mode == 2'b01) |=> !hrq);

  a_r9_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_now && !tc_hit && sel_mode == 2'b10) |=> hrq);

  a_r12_mask_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit && !sel_auto) |=> chan_mask[$past(sel_ch)]);

  a_r12_auto_open: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit && sel_auto) |=> !chan_mask[$past(sel_ch)]);

endmodule

bind dma_xfer_seq dmaseq_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hrq       (hrq),
  .hlda      (hlda),
  .dack      (dack),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .io_rd     (io_rd),
  .io_wr     (io_wr),
  .tc        (tc),
  .xfer_now  (xfer_now),
  .tc_hit    (tc_hit),
  .sel_ch    (sel_ch),
  .sel_auto  (sel_auto),
  .sel_mode  (sel_mode),
  .chan_mask (chan_mask)
);

// File: tb/sim_dma_xfer_seq.sv
module sim_dma_xfer_seq;

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  mode;
    logic        dec;
    logic        aut;
    logic [1:0]  typ;
    logic [7:0]  page;
    logic [15:0] ofs;
    logic [15:0] cnt;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'b01, 1'b0, 1'b0, 2'b01, 8'h12, 16'h1000, 16'd3},
    '{2'd1, 2'b10, 1'b1, 1'b0, 2'b10, 8'h03, 16'h0002, 16'd4},
    '{2'd2, 2'b00, 1'b0, 1'b1, 2'b01, 8'hA5, 16'hFFFE, 16'd2},
    '{2'd3, 2'b10, 1'b0, 1'b0, 2'b00, 8'h00, 16'h0100, 16'd0},
    '{2'd0, 2'b01, 1'b1, 1'b1, 2'b10, 8'h7F, 16'h8000, 16'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dreq = '0;
  logic        hrq;
  logic        hlda = 1'b0;
  logic [3:0]  dack;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr, tc;
  logic        prog_en = 1'b0;
  logic [1:0]  prog_ch = '0;
  logic [1:0]  prog_mode = '0;
  logic        prog_dec = 1'b0;
  logic        prog_auto = 1'b0;
  logic [1:0]  prog_type = '0;
  logic [7:0]  prog_page = '0;
  logic [15:0] prog_ofs = '0;
  logic [15:0] prog_cnt = '0;
  logic [3:0]  chan_mask;

  always #2 clk = ~clk;

  dma_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .hrq(hrq), .hlda(hlda), .dack(dack),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .tc(tc), .prog_en(prog_en), .prog_ch(prog_ch),
    .prog_mode(prog_mode), .prog_dec(prog_dec), .prog_auto(prog_auto),
    .prog_type(prog_type), .prog_page(prog_page), .prog_ofs(prog_ofs),
    .prog_cnt(prog_cnt), .chan_mask(chan_mask)
  );

  int nvec = 0, nfail = 0, cyc = 0;
  int hl_lat = 0, hw = 0;
  bit done = 0;

  // Processor model: grants the bus hl_lat cycles after hrq, drops with it
  always @(posedge clk) begin
    if (!hrq) begin hlda <= 1'b0; hw <= 0; end
    else if (hw >= hl_lat) hlda <= 1'b1;
    else hw <= hw + 1;
  end

  // Transfer log filled at falling edges
  logic [1:0]  lg_ch   [64];
  logic [23:0] lg_addr [64];
  logic [3:0]  lg_str  [64];
  logic        lg_tc   [64];
  int lg_n = 0, bursts = 0, early = 0;
  logic hrq_q = 1'b0;

  function automatic logic [1:0] enc(input logic [3:0] d);
    return d[0] ? 2'd0 : d[1] ? 2'd1 : d[2] ? 2'd2 : 2'd3;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (hrq && !hrq_q) bursts++;
      hrq_q = hrq;
      if (dack != '0) begin
        if (!hlda) early++;
        if (lg_n < 64) begin
          lg_ch[lg_n]   = enc(dack);
          lg_addr[lg_n] = mem_addr;
          lg_str[lg_n]  = {mem_rd, mem_wr, io_rd, io_wr};
          lg_tc[lg_n]   = tc;
          lg_n++;
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      nvec++; nfail++;
      $display("FAIL watchdog: got %0d cycles expected < 100000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected values, restated from the requirements
  function automatic logic [3:0] exp_str(input logic [1:0] t);
    return (t == 2'b01) ? 4'b0110 : (t == 2'b10) ? 4'b1001 : 4'b0000;
  endfunction

  function automatic logic [15:0] exp_ofs(input logic [15:0] b, input logic d, input int k);
    return d ? 16'(b - 16'(k)) : 16'(b + 16'(k));
  endfunction

  task automatic load(input vec_t v);
    @(negedge clk);
    prog_ch = v.ch; prog_mode = v.mode; prog_dec = v.dec; prog_auto = v.aut;
    prog_type = v.typ; prog_page = v.page; prog_ofs = v.ofs; prog_cnt = v.cnt;
    prog_en = 1'b1;
    @(negedge clk);
    prog_en = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk);
    lg_n = 0; bursts = 0;
  endtask

  task automatic wait_tc(input int ch);
    int t = 0;
    do begin @(negedge clk); t++; end while (!tc && t < 400);
    dreq[ch] = 1'b0;
    chk(t < 400, "R7", "tc reached", t, 400);
  endtask

  task automatic run_vec(input vec_t v, input bit do_load);
    int n;
    string mr;
    if (do_load) load(v);
    clear_log();
    dreq[v.ch] = 1'b1;
    wait_tc(v.ch);
    repeat (8) @(negedge clk);
    n = int'(v.cnt) + 1;
    chk(lg_n == n, "R7", "transfer count", lg_n, n);
    for (int k = 0; k < n && k < lg_n; k++) begin
      chk(lg_ch[k] == v.ch, "R4", "dack channel", lg_ch[k], v.ch);
      chk(lg_addr[k] == {v.page, exp_ofs(v.ofs, v.dec, k)}, "R6", "address",
          lg_addr[k], {v.page, exp_ofs(v.ofs, v.dec, k)});
      chk(lg_str[k] == exp_str(v.typ), "R5", "strobes", lg_str[k], exp_str(v.typ));
      chk(lg_tc[k] == (k == n - 1), "R7", "tc position", lg_tc[k], (k == n - 1));
    end
    mr = (v.mode == 2'b01) ? "R8" : (v.mode == 2'b10) ? "R9" : "R10";
    chk(bursts == ((v.mode == 2'b01) ? n : 1), mr, "hold count", bursts,
        (v.mode == 2'b01) ? n : 1);
    chk(chan_mask[v.ch] == !v.aut, "R12", "mask after tc", chan_mask[v.ch], !v.aut);
  endtask

  initial begin
    vec_t v;
    int k;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!hrq && dack == '0 && !tc, "R1", "hrq/dack/tc", {hrq, dack, tc}, 0);
    chk({mem_rd, mem_wr, io_rd, io_wr} == '0, "R1", "strobes", {mem_rd, mem_wr, io_rd, io_wr}, 0);
    chk(chan_mask == 4'hF, "R1", "mask", chan_mask, 4'hF);

    // R2: unloaded channels stay masked
    clear_log();
    dreq = 4'hF;
    repeat (20) @(negedge clk);
    chk(bursts == 0 && lg_n == 0, "R2", "masked requests", lg_n + bursts, 0);
    dreq = '0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      hl_lat = i % 3;
      run_vec(VECS[i], 1'b1);
    end

    // R2/R12: channel 1 masked itself at tc; its request is ignored
    clear_log();
    dreq[1] = 1'b1;
    repeat (20) @(negedge clk);
    chk(lg_n == 0 && !hrq, "R2", "request after tc", lg_n, 0);
    dreq = '0;

    // R12: reload channels rerun from their start values
    hl_lat = 2;
    run_vec(VECS[2], 1'b0);
    run_vec(VECS[4], 1'b0);

    // R11: simultaneous requests, lowest channel first
    hl_lat = 0;
    load('{2'd1, 2'b01, 1'b0, 1'b0, 2'b01, 8'h00, 16'h0040, 16'd1});
    load('{2'd2, 2'b01, 1'b0, 1'b0, 2'b10, 8'h00, 16'h0080, 16'd1});
    clear_log();
    dreq = 4'b0110;
    k = 0;
    while (!(chan_mask[1] && chan_mask[2]) && k < 200) begin @(negedge clk); k++; end
    dreq = '0;
    repeat (4) @(negedge clk);
    chk(lg_n == 4, "R11", "transfer count", lg_n, 4);
    chk({lg_ch[0], lg_ch[1], lg_ch[2], lg_ch[3]} == 8'b01_01_10_10, "R11", "order",
        {lg_ch[0], lg_ch[1], lg_ch[2], lg_ch[3]}, 8'b01_01_10_10);

    // R10: demand mode pauses when the request drops, then resumes
    hl_lat = 1;
    v = '{2'd0, 2'b00, 1'b0, 1'b0, 2'b01, 8'h01, 16'h0010, 16'd4};
    load(v);
    clear_log();
    dreq[0] = 1'b1;
    k = 0;
    while (k < 2) begin @(negedge clk); if (dack[0]) k++; end
    dreq[0] = 1'b0;
    repeat (10) @(negedge clk);
    chk(lg_n == 2 && bursts == 1, "R10", "paused run", {lg_n, bursts}, {2, 1});
    chk(!hrq && !chan_mask[0], "R10", "bus released", {hrq, chan_mask[0]}, 0);
    dreq[0] = 1'b1;
    wait_tc(0);
    repeat (8) @(negedge clk);
    chk(lg_n == 5 && bursts == 2, "R10", "resumed run", {lg_n, bursts}, {5, 2});
    for (int j = 0; j < 5 && j < lg_n; j++) begin
      chk(lg_addr[j] == {8'h01, 16'(16'h0010 + j)}, "R10", "resume address",
          lg_addr[j], {8'h01, 16'(16'h0010 + j)});
      chk(lg_tc[j] == (j == 4), "R7", "tc position", lg_tc[j], (j == 4));
    end

    // R9: block mode keeps going after the request is withdrawn
    load('{2'd3, 2'b10, 1'b0, 1'b0, 2'b01, 8'h02, 16'h0200, 16'd3});
    clear_log();
    dreq[3] = 1'b1;
    k = 0;
    while (!dack[3] && k < 50) begin @(negedge clk); k++; end
    dreq[3] = 1'b0;
    repeat (20) @(negedge clk);
    chk(lg_n == 4 && bursts == 1, "R9", "block after drop", {lg_n, bursts}, {4, 1});
    chk(lg_n == 4 && lg_tc[3], "R9", "tc at end", lg_tc[3], 1);

    // R3: no acknowledge ever seen without the grant
    chk(early == 0, "R3", "dack without hlda", early, 0);

    done = 1;
    summary();
  end

endmodule